// File: doc/BRIEF.md
# Store-Set Load/Store Ordering Predictor

This block decides, at fetch time, whether a memory instruction has to hold back behind an earlier in-flight store. It learns from memory-order violations. When a load ran ahead of a store that wrote the same location, the two PCs are tied to a common set identifier. From then on, a load in that set waits for the newest fetched store of the set. A store in that set waits for the store of the set fetched before it, so the stores of a set issue in order and a load behind them is ordered against all of them.

Two tables hold the learned state. A direct-mapped identifier table of 256 entries is indexed by PC bits [9:2]; each entry holds a valid bit and a 6-bit set identifier. A newest-store table of 64 entries is indexed by the set identifier and holds a valid bit and a 6-bit instruction tag. Lookups are combinational, so a fetch gets its answer in the same cycle. Table updates take effect at the next rising clock edge. A clear request empties both tables, and the core can pulse it at regular intervals to break up stale or aliased sets.

Top module: `ldsp_storeset_pred`

## Requirements
- R1: After reset, no fetched load or store is told to wait.
- R2: A load or store whose identifier entry is invalid gets no wait and changes no state. When `fe_wait` is 0, `fe_wait_tag` reads 0.
- R3: A violation in which neither PC has a valid identifier entry gives both PCs the set identifier equal to store PC bits [7:2].
- R4: A fetched store with a valid identifier waits for the tag held in its set's newest-store entry, if that entry is valid. It then becomes that set's newest store, with its own tag.
- R5: A fetched load with a valid identifier waits for its set's newest-store tag when that entry is valid. Loads never change either table. A fetch with `fe_valid` low gives no wait and changes nothing.
- R6: A violation in which only one of the two PCs has a valid identifier puts the other PC into that same set.
- R7: A violation in which both PCs have valid identifiers gives both PCs the smaller of the two identifiers.
- R8: An issued store clears its set's newest-store entry only when that entry holds the issued store's tag.
- R9: A one-cycle `clr_req` invalidates every entry of both tables, effective from the next cycle.
- R10: The identifier table is direct-mapped on PC bits [9:2]. PCs that differ only in bits [1:0] or above bit 9 share an entry.
- R11: When a store fetch and a store issue update the same newest-store entry in one cycle, the fetched store's record is the one kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fe_valid | input | 1 | A memory instruction is fetched this cycle |
| fe_pc | input | 32 | PC of the fetched instruction |
| fe_is_store | input | 1 | 1 = store, 0 = load |
| fe_tag | input | 6 | In-flight tag of the fetched instruction |
| fe_wait | output | 1 | The fetched instruction must wait |
| fe_wait_tag | output | 6 | Tag of the store to wait for (0 when no wait) |
| vio_valid | input | 1 | A memory-order violation is reported |
| vio_ld_pc | input | 32 | PC of the load that ran ahead |
| vio_st_pc | input | 32 | PC of the store it passed |
| iss_valid | input | 1 | A store issued this cycle |
| iss_pc | input | 32 | PC of the issued store |
| iss_tag | input | 6 | Tag of the issued store |
| clr_req | input | 1 | Invalidate both tables |

## Verification
A wrong identifier entry shows up at the next fetch of an affected load. The load either waits on a store of a foreign set or stops waiting on its real producer. This is why every learned set is probed with a store fetch followed by a load fetch one cycle later. A corrupted newest-store entry appears on the very next fetch of any member of that set, as a wrong or missing `fe_wait_tag`. The merge rule can only be seen after a further store fetch on one side of the merged pair. A stale entry left by an issue-clear that was wrongly matched or missed shows up when the set's load is fetched again.

// File: rtl/ldsp_pkg.sv
package ldsp_pkg;

    localparam int PC_W   = 32;
    localparam int SIT_AW = 8;
    localparam int SIT_N  = 1 << SIT_AW;
    localparam int SSID_W = 6;
    localparam int LFST_N = 1 << SSID_W;
    localparam int TAG_W  = 6;
    localparam int NRD    = 4;

    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [SIT_AW-1:0] sit_idx_t;
    typedef logic [SSID_W-1:0] ssid_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef struct packed {
        logic  vld;
        ssid_t id;
    } sit_ent_t;

    typedef struct packed {
        logic vld;
        tag_t tag;
    } lfst_ent_t;

    typedef enum logic [1:0] {
        MRG_NONE  = 2'b00,
        MRG_STORE = 2'b01,
        MRG_LOAD  = 2'b10,
        MRG_BOTH  = 2'b11
    } mrg_case_e;

    function automatic sit_idx_t pc_to_idx(input pc_t pc);
        return pc[SIT_AW+1:2];
    endfunction

    function automatic ssid_t min_id(input ssid_t a, input ssid_t b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/ldsp_sit.sv
module ldsp_sit
    import ldsp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     wr_en,
    input  sit_idx_t wr_a,
    input  sit_idx_t wr_b,
    input  ssid_t    wr_id,
    input  sit_idx_t rd_idx [NRD],
    output sit_ent_t rd_ent [NRD]
);

    sit_ent_t mem [SIT_N];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < SIT_N; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_a] <= '{vld: 1'b1, id: wr_id};
            mem[wr_b] <= '{vld: 1'b1, id: wr_id};
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_ent[g] = mem[rd_idx[g]];
    end

    AST_SIT_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> !mem[rd_idx[0]].vld && !mem[rd_idx[3]].vld); // R9

    AST_SIT_PAIR_SHARES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr) |=> (mem[$past(wr_a)] == mem[$past(wr_b)]) && mem[$past(wr_a)].vld); // R7

endmodule

// File: rtl/ldsp_lfst.sv
module ldsp_lfst
    import ldsp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      rec_en,
    input  ssid_t     rec_id,
    input  tag_t      rec_tag,
    input  logic      rel_en,
    input  ssid_t     rel_id,
    input  tag_t      rel_tag,
    input  ssid_t     rd_id,
    output lfst_ent_t rd_ent
);

    lfst_ent_t mem [LFST_N];
    logic      rel_hit;

    assign rel_hit = rel_en && mem[rel_id].vld && (mem[rel_id].tag == rel_tag);
    assign rd_ent  = mem[rd_id];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < LFST_N; i++) mem[i] <= '0;
        end else begin
            if (rel_hit) mem[rel_id].vld <= 1'b0;
            if (rec_en)  mem[rec_id] <= '{vld: 1'b1, tag: rec_tag};
        end
    end

    AST_LFST_REC_KEPT: assert property (@(posedge clk) disable iff (rst)
        (rec_en && !clr) |=> mem[$past(rec_id)].vld && (mem[$past(rec_id)].tag == $past(rec_tag))); // R11

    AST_LFST_MISMATCH_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (rel_en && !rec_en && !clr && mem[rel_id].vld && (mem[rel_id].tag != rel_tag))
        |=> mem[$past(rel_id)].vld); // R8

endmodule

// File: rtl/ldsp_merge.sv
module ldsp_merge
    import ldsp_pkg::*;
(
    input  sit_ent_t ld_ent,
    input  sit_ent_t st_ent,
    input  sit_idx_t st_idx,
    output ssid_t    new_id
);

    mrg_case_e mcase;

    assign mcase = mrg_case_e'({ld_ent.vld, st_ent.vld});

    always_comb begin
        unique case (mcase)
            MRG_NONE:  new_id = st_idx[SSID_W-1:0];
            MRG_STORE: new_id = st_ent.id;
            MRG_LOAD:  new_id = ld_ent.id;
            MRG_BOTH:  new_id = min_id(ld_ent.id, st_ent.id);
            default:   new_id = '0;
        endcase
    end

endmodule

// File: rtl/ldsp_storeset_pred.sv
module ldsp_storeset_pred
    import ldsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fe_valid,
    input  logic [PC_W-1:0]   fe_pc,
    input  logic              fe_is_store,
    input  logic [TAG_W-1:0]  fe_tag,
    output logic              fe_wait,
    output logic [TAG_W-1:0]  fe_wait_tag,
    input  logic              vio_valid,
    input  logic [PC_W-1:0]   vio_ld_pc,
    input  logic [PC_W-1:0]   vio_st_pc,
    input  logic              iss_valid,
    input  logic [PC_W-1:0]   iss_pc,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic              clr_req
);

    localparam int P_FE  = 0;
    localparam int P_VLD = 1;
    localparam int P_VST = 2;
    localparam int P_ISS = 3;

    sit_idx_t  rd_idx [NRD];
    sit_ent_t  rd_ent [NRD];
    ssid_t     mrg_id;
    lfst_ent_t lf_ent;
    logic      rec_en;
    logic      rel_en;

    assign rd_idx[P_FE]  = pc_to_idx(fe_pc);
    assign rd_idx[P_VLD] = pc_to_idx(vio_ld_pc);
    assign rd_idx[P_VST] = pc_to_idx(vio_st_pc);
    assign rd_idx[P_ISS] = pc_to_idx(iss_pc);

    ldsp_merge u_merge (
        .ld_ent (rd_ent[P_VLD]),
        .st_ent (rd_ent[P_VST]),
        .st_idx (rd_idx[P_VST]),
        .new_id (mrg_id)
    );

    ldsp_sit u_sit (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr_req),
        .wr_en  (vio_valid),
        .wr_a   (rd_idx[P_VLD]),
        .wr_b   (rd_idx[P_VST]),
        .wr_id  (mrg_id),
        .rd_idx (rd_idx),
        .rd_ent (rd_ent)
    );

    assign rec_en = fe_valid && fe_is_store && rd_ent[P_FE].vld;
    assign rel_en = iss_valid && rd_ent[P_ISS].vld;

    ldsp_lfst u_lfst (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_req),
        .rec_en  (rec_en),
        .rec_id  (rd_ent[P_FE].id),
        .rec_tag (fe_tag),
        .rel_en  (rel_en),
        .rel_id  (rd_ent[P_ISS].id),
        .rel_tag (iss_tag),
        .rd_id   (rd_ent[P_FE].id),
        .rd_ent  (lf_ent)
    );

    assign fe_wait     = fe_valid && rd_ent[P_FE].vld && lf_ent.vld;
    assign fe_wait_tag = fe_wait ? lf_ent.tag : '0;

    AST_CLR_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> !fe_wait); // R9

    AST_IDLE_TAG_ZERO: assert property (@(posedge clk) disable iff (rst)
        !fe_wait |-> (fe_wait_tag == '0)); // R2

endmodule

// File: tb/ldsp_storeset_pred_tb.sv
module ldsp_storeset_pred_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fe_valid = 1'b0;
    logic [31:0] fe_pc = '0;
    logic        fe_is_store = 1'b0;
    logic [5:0]  fe_tag = '0;
    logic        fe_wait;
    logic [5:0]  fe_wait_tag;
    logic        vio_valid = 1'b0;
    logic [31:0] vio_ld_pc = '0;
    logic [31:0] vio_st_pc = '0;
    logic        iss_valid = 1'b0;
    logic [31:0] iss_pc = '0;
    logic [5:0]  iss_tag = '0;
    logic        clr_req = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ldsp_storeset_pred u_dut (
        .clk(clk), .rst(rst),
        .fe_valid(fe_valid), .fe_pc(fe_pc), .fe_is_store(fe_is_store), .fe_tag(fe_tag),
        .fe_wait(fe_wait), .fe_wait_tag(fe_wait_tag),
        .vio_valid(vio_valid), .vio_ld_pc(vio_ld_pc), .vio_st_pc(vio_st_pc),
        .iss_valid(iss_valid), .iss_pc(iss_pc), .iss_tag(iss_tag),
        .clr_req(clr_req)
    );

    task automatic check_out(input logic ew, input logic [5:0] et, input string req);
        checks++;
        if (fe_wait !== ew || fe_wait_tag !== (ew ? et : 6'd0)) begin
            errors++;
            $display("FAIL %s: actual wait=%0b tag=%0d expected wait=%0b tag=%0d",
                     req, fe_wait, fe_wait_tag, ew, ew ? et : 6'd0);
        end
    endtask

    task automatic fetch(input logic [31:0] pc, input logic st, input logic [5:0] tag,
                         input logic ew, input logic [5:0] et, input string req);
        @(negedge clk);
        fe_valid = 1'b1; fe_pc = pc; fe_is_store = st; fe_tag = tag;
        #1 check_out(ew, et, req);
        @(posedge clk); #1 fe_valid = 1'b0;
    endtask

    task automatic violate(input logic [31:0] ldpc, input logic [31:0] stpc);
        @(negedge clk);
        vio_valid = 1'b1; vio_ld_pc = ldpc; vio_st_pc = stpc;
        @(posedge clk); #1 vio_valid = 1'b0;
    endtask

    task automatic issue(input logic [31:0] pc, input logic [5:0] tag);
        @(negedge clk);
        iss_valid = 1'b1; iss_pc = pc; iss_tag = tag;
        @(posedge clk); #1 iss_valid = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk); clr_req = 1'b1;
        @(posedge clk); #1 clr_req = 1'b0;
    endtask

    task automatic finish_up();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: empty after reset
        fetch(32'h0000_0200, 1'b0, 6'd1, 1'b0, 6'd0, "R1");
        fetch(32'h0000_0010, 1'b1, 6'd2, 1'b0, 6'd0, "R1");
        // R2: store with no set does not record; later load still unlisted
        fetch(32'h0000_0010, 1'b1, 6'd3, 1'b0, 6'd0, "R2");

        // R3: train 64 fresh pairs; store idx k, load idx 128+k, id = k
        for (int k = 0; k < 64; k++) violate((128 + k) * 4, k * 4);
        for (int k = 0; k < 64; k++) begin
            fetch(k * 4, 1'b1, 6'(k), 1'b0, 6'd0, "R4");
            fetch((128 + k) * 4, 1'b0, 6'd0, 1'b1, 6'(k), "R3");
        end
        // R5: loads do not alter the record
        for (int k = 0; k < 64; k++)
            fetch((128 + k) * 4, 1'b0, 6'd7, 1'b1, 6'(k), "R5");
        // R4: second store waits on first, then replaces it
        for (int k = 0; k < 64; k++)
            fetch(k * 4, 1'b1, 6'((k + 1) % 64), 1'b1, 6'(k), "R4");
        // R8: wrong tag keeps the entry, matching tag clears it
        for (int k = 0; k < 64; k++) begin
            issue(k * 4, 6'(k));
            fetch((128 + k) * 4, 1'b0, 6'd0, 1'b1, 6'((k + 1) % 64), "R8");
            issue(k * 4, 6'((k + 1) % 64));
            fetch((128 + k) * 4, 1'b0, 6'd0, 1'b0, 6'd0, "R8");
        end

        // R10: aliasing through upper and low PC bits
        fetch(5 * 4 + 2048, 1'b1, 6'd9, 1'b0, 6'd0, "R10");
        fetch((128 + 5) * 4 + 4096 + 1, 1'b0, 6'd0, 1'b1, 6'd9, "R10");

        // R5: fetch with valid low has no effect
        @(negedge clk);
        fe_valid = 1'b0; fe_pc = 5 * 4; fe_is_store = 1'b1; fe_tag = 6'd44;
        #1 check_out(1'b0, 6'd0, "R5");
        @(posedge clk);
        fetch((128 + 5) * 4, 1'b0, 6'd0, 1'b1, 6'd9, "R5");

        // R9: clear empties both tables
        clear_all();
        fetch((128 + 5) * 4, 1'b0, 6'd0, 1'b0, 6'd0, "R9");
        fetch(5 * 4, 1'b1, 6'd20, 1'b0, 6'd0, "R9");
        fetch((128 + 5) * 4, 1'b0, 6'd0, 1'b0, 6'd0, "R9");

        // R6: one side already in a set
        violate(32'h300, 32'h10);
        violate(32'h304, 32'h10);
        fetch(32'h10, 1'b1, 6'd11, 1'b0, 6'd0, "R6");
        fetch(32'h304, 1'b0, 6'd0, 1'b1, 6'd11, "R6");
        violate(32'h300, 32'h20);
        fetch(32'h20, 1'b1, 6'd12, 1'b1, 6'd11, "R6");
        fetch(32'h300, 1'b0, 6'd0, 1'b1, 6'd12, "R6");

        // R7: merge of sets 2 and 10 keeps 2
        clear_all();
        violate(32'h320, 32'h08);
        violate(32'h324, 32'h28);
        violate(32'h320, 32'h28);
        fetch(32'h08, 1'b1, 6'd21, 1'b0, 6'd0, "R7");
        fetch(32'h320, 1'b0, 6'd0, 1'b1, 6'd21, "R7");
        fetch(32'h28, 1'b1, 6'd22, 1'b1, 6'd21, "R7");
        fetch(32'h324, 1'b0, 6'd0, 1'b0, 6'd0, "R7");

        // R11: same-cycle record and release on set 2
        @(negedge clk);
        fe_valid = 1'b1; fe_pc = 32'h08; fe_is_store = 1'b1; fe_tag = 6'd30;
        iss_valid = 1'b1; iss_pc = 32'h08; iss_tag = 6'd22;
        #1 check_out(1'b1, 6'd22, "R11");
        @(posedge clk); #1 begin fe_valid = 1'b0; iss_valid = 1'b0; end
        fetch(32'h320, 1'b0, 6'd0, 1'b1, 6'd30, "R11");
        issue(32'h28, 6'd30);
        fetch(32'h320, 1'b0, 6'd0, 1'b0, 6'd0, "R8");

        finish_up();
    end

endmodule